// File: doc/BRIEF.md
# PCM serial transmit port

This block sends one companded 8-bit PCM sample per frame through a serial data pin that is driven only inside the transmit time slot. A parallel code is written into a holding register through a load strobe. When a frame begins, that code moves into a shift register and leaves most significant bit first. The bit clock and the transmit frame sync come from the system. Both are sampled by a faster local clock. Their edges are found by comparing the current sample with the previous one.

The port tells short frame sync from long frame sync by itself, from the length of each completed sync pulse. The two modes turn the output on and off at different events. An active-low slot strobe marks the transmit window. A power-down input blanks the port. After power-down is released, the output stays off until the second sync pulse, and that pulse is the first one that carries data.

Top module: `pcm_tx_port`

## Requirements
- R1: After reset the port is powered down and in short-frame mode: `sd_oe_o` is 0, `slot_n_o` is 1, `sd_o` is 0 and `long_mode_o` is 0. No slot opens until `pdn_i` is low and the sync sequence of R8 has happened.
- R2: Each completed sync pulse is measured as the number of bit-clock falling edges seen while sync is high. A count of 1 or 2 selects short mode and a count of 3 or more selects long mode (`long_mode_o` = 1). The new mode shows after the pulse ends and governs the next frame, not the frame in progress.
- R3: In short mode a slot is armed by a bit-clock falling edge that sees sync high. The next rising edge turns the output on with bit 7. Each of the next seven rising edges moves on by one bit. The falling edge after the bit-0 rising edge turns the output off.
- R4: In long mode the output turns on with bit 7 at whichever comes later, the sync rising edge or a bit-clock rising edge. Each of the next seven bit-clock rising edges moves on by one bit.
- R5: In long mode, once bit 0 is on the line, the output turns off at the later of the next bit-clock falling edge and sync going low.
- R6: The code sent in a slot is the code most recently loaded before the slot begins. A load made while a slot is shifting does not change that slot's bits.
- R7: While `pdn_i` is high the output stays off, no shifting takes place, and the mode returns to short. Raising `pdn_i` in the middle of a slot turns the output off within two system clock cycles.
- R8: After `pdn_i` falls, the first sync pulse opens no slot and the second sync pulse opens one.
- R9: `slot_n_o` is low exactly while `sd_oe_o` is high, and `sd_o` is held at 0 whenever `sd_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system sampling clock, faster than the bit clock |
| rst_n | input | 1 | active-low asynchronous reset |
| bclk_i | input | 1 | serial bit clock |
| fs_i | input | 1 | transmit frame sync |
| pdn_i | input | 1 | power-down, active high |
| code_i | input | W | parallel PCM code |
| code_ld_i | input | 1 | load strobe for `code_i` |
| sd_o | output | 1 | serial data, 0 when not enabled |
| sd_oe_o | output | 1 | output enable for the serial data pin |
| slot_n_o | output | 1 | active-low time-slot strobe |
| long_mode_o | output | 1 | 1 when long-frame mode is in force |

## Verification
A load of the holding register can fall in the same cycles as a slot that is shifting out. To provoke this, the bench writes the next frame's code during the fifth bit period of every frame. It then checks that the current slot still carries the earlier code and that the following slot carries the new one. A second overlap is power-down raised in the middle of a long-mode slot. That case is judged by the enable dropping at once and by the mode falling back to short.

// File: rtl/pcm_tx_port.sv
module pcm_tx_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bclk_i,
  input  logic         fs_i,
  input  logic         pdn_i,
  input  logic [W-1:0] code_i,
  input  logic         code_ld_i,
  output logic         sd_o,
  output logic         sd_oe_o,
  output logic         slot_n_o,
  output logic         long_mode_o
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] PRE = CW'(W - 2);

  logic bclk_q, bclk_p, fs_q, fs_p, pd_q;
  logic [W-1:0] hold, sr;
  logic [CW-1:0] cnt;
  logic [1:0] plen, seen;
  logic oe, pend, tail, fall_seen, started, frame_long, long_mode;

  wire b_rise = bclk_q & ~bclk_p;
  wire b_fall = ~bclk_q & bclk_p;
  wire f_rise = fs_q & ~fs_p;
  wire f_fall = ~fs_q & fs_p;
  wire busy   = oe | pend;
  wire ok     = (seen == 2'd2) || (f_rise && seen == 2'd1);
  wire go_s   = !long_mode && fs_q && b_fall && !started && !busy && ok;
  wire go_l   = long_mode && fs_q && bclk_q && !started && !busy && ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b0; bclk_p <= 1'b0;
      fs_q   <= 1'b0; fs_p   <= 1'b0;
      pd_q   <= 1'b1;
    end else begin
      bclk_q <= bclk_i; bclk_p <= bclk_q;
      fs_q   <= fs_i;   fs_p   <= fs_q;
      pd_q   <= pdn_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold <= '0;
    else if (code_ld_i) hold <= code_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0; cnt <= '0; plen <= '0; seen <= '0;
      oe <= 1'b0; pend <= 1'b0; tail <= 1'b0; fall_seen <= 1'b0;
      started <= 1'b0; frame_long <= 1'b0; long_mode <= 1'b0;
    end else if (pd_q) begin
      cnt <= '0; plen <= '0; seen <= '0;
      oe <= 1'b0; pend <= 1'b0; tail <= 1'b0; fall_seen <= 1'b0;
      started <= 1'b0; long_mode <= 1'b0;
    end else begin
      if (f_rise) plen <= {1'b0, b_fall};
      else if (fs_q && b_fall && plen != 2'd3) plen <= plen + 2'd1;
      if (f_fall) long_mode <= (plen == 2'd3);
      if (f_rise && seen != 2'd2) seen <= seen + 2'd1;
      if (!fs_q) started <= 1'b0;

      if (go_s) begin
        pend <= 1'b1; started <= 1'b1; sr <= hold; frame_long <= 1'b0;
      end else if (go_l) begin
        oe <= 1'b1; cnt <= '0; tail <= 1'b0; fall_seen <= 1'b0;
        started <= 1'b1; sr <= hold; frame_long <= 1'b1;
      end else if (pend) begin
        if (b_rise) begin
          pend <= 1'b0; oe <= 1'b1; cnt <= '0; tail <= 1'b0; fall_seen <= 1'b0;
        end
      end else if (oe) begin
        if (!tail) begin
          if (b_rise) begin
            sr  <= sr << 1;
            cnt <= cnt + 1'b1;
            if (cnt == PRE) tail <= 1'b1;
          end
        end else if (!frame_long) begin
          if (b_fall) begin oe <= 1'b0; tail <= 1'b0; end
        end else begin
          if (b_fall) fall_seen <= 1'b1;
          if ((fall_seen || b_fall) && !fs_q) begin
            oe <= 1'b0; tail <= 1'b0; fall_seen <= 1'b0;
          end
        end
      end
    end
  end

  assign sd_o        = oe & sr[W-1];
  assign sd_oe_o     = oe;
  assign slot_n_o    = ~oe;
  assign long_mode_o = long_mode;
endmodule

module pcm_tx_port_chk (
  input logic clk,
  input logic rst_n,
  input logic bclk_i,
  input logic fs_i,
  input logic pdn_i,
  input logic sd_o,
  input logic sd_oe_o,
  input logic long_mode_o
);
  p_pdn_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pdn_i, 2) |-> !sd_oe_o);

  p_rise_needs_power_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_oe_o) |-> !$past(pdn_i, 2));

  p_mode_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(long_mode_o) |-> (!$past(fs_i, 2) || $past(pdn_i, 2)));

  p_shift_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sd_oe_o) && sd_oe_o && !$stable(sd_o)) |-> ($past(bclk_i, 2) && !$past(bclk_i, 3)));

  p_off_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sd_oe_o) |-> ($past(pdn_i, 2) || !$past(fs_i, 2) ||
                        (!$past(bclk_i, 2) && $past(bclk_i, 3))));
endmodule

bind pcm_tx_port pcm_tx_port_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .fs_i(fs_i), .pdn_i(pdn_i),
  .sd_o(sd_o), .sd_oe_o(sd_oe_o), .long_mode_o(long_mode_o)
);

// File: tb/pcm_tx_port_tb.sv
`timescale 1ns/1ps
module pcm_tx_port_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, bclk = 1'b0, fs = 1'b0, pdn = 1'b1, code_ld = 1'b0;
  logic [7:0] code = '0;
  logic sd, sd_oe, slot_n, long_mode;
  int checks = 0, errors = 0;
  logic [7:0] hold_m = '0;

  always #4 clk = ~clk;

  pcm_tx_port #(.W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .fs_i(fs), .pdn_i(pdn),
    .code_i(code), .code_ld_i(code_ld), .sd_o(sd), .sd_oe_o(sd_oe),
    .slot_n_o(slot_n), .long_mode_o(long_mode)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // stim 0: sync rises in bclk high half; stim 1: sync rises in bclk low half
  // pat 0: no slot, 1: short-mode slot, 2: long-mode slot
  task automatic run_frame(input int stim, input int len, input int pat, input int pd_at,
                           input logic [7:0] nxt, input string req);
    logic [7:0] ec;
    int mode_e;
    ec = hold_m;
    for (int p = 0; p < 12; p++) begin
      for (int ph = 0; ph < 2; ph++) begin
        for (int n = 0; n < 8; n++) begin
          @(negedge clk);
          if (n == 0) bclk = (ph == 0);
          if (n == 2) begin
            if (stim == 0 && ph == 0 && p == 1) fs = 1'b1;
            if (stim == 0 && ph == 0 && p == len + 1) fs = 1'b0;
            if (stim == 1 && ph == 1 && p == 0) fs = 1'b1;
            if (stim == 1 && ph == 1 && p == len) fs = 1'b0;
            if (pd_at >= 0 && p == pd_at && ph == 0) pdn = 1'b1;
          end
          if (n == 5 && p == 5 && ph == 0) begin code = nxt; code_ld = 1'b1; end
          if (n == 6) begin
            bit hi, on;
            int idx;
            code_ld = 1'b0;
            hi = (ph == 0);
            on = 1'b0; idx = 0;
            if (pat == 1) begin
              on = (p >= 2 && p <= 8) || (p == 9 && hi);
              idx = p - 2;
            end else if (pat == 2) begin
              on = (p >= 1) && (p <= 7 || (p == 8 && (hi || (stim == 0 && len >= 8))));
              idx = p - 1;
            end
            if (pd_at >= 0 && p >= pd_at) on = 1'b0;
            // R9: strobe mirrors enable, data idles at 0
            check(req, {sd_oe, slot_n, sd},
                  {on, ~on, on ? ec[7 - idx] : 1'b0});
          end
        end
      end
    end
    hold_m = nxt;
    mode_e = (pd_at >= 0 || pdn) ? 0 : (len >= 3 ? 1 : 0);
    check("R2 mode", int'(long_mode), mode_e);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check("R1 reset enable/strobe/data/mode", {sd_oe, slot_n, sd, long_mode}, 4'b0100);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after reset", {sd_oe, slot_n, sd, long_mode}, 4'b0100);
    run_frame(0, 1, 0, -1, 8'h3C, "R7 powered down");
    pdn = 1'b0;
    run_frame(0, 1, 0, -1, 8'hC3, "R8 first sync");
    for (int c = 0; c < 256; c++)
      run_frame(0, (c % 2) + 1, 1, -1, 8'(c ^ 8'h5A), "R3 R6 short slot");
    run_frame(0, 3, 1, -1, 8'h81, "R2 mode applies next frame");
    for (int l = 3; l <= 8; l++)
      run_frame(0, l, 2, -1, 8'(8'h11 * l), "R4 R5 long, sync rises last");
    for (int l = 3; l <= 8; l++)
      run_frame(1, l, 2, -1, 8'(~(8'h13 * l)), "R4 R5 long, bclk rises last");
    run_frame(0, 2, 2, -1, 8'h96, "R2 long to short");
    run_frame(0, 1, 1, -1, 8'h69, "R2 short again");
    run_frame(0, 4, 1, -1, 8'hF0, "R2 to long");
    run_frame(0, 5, 2, 4, 8'h0F, "R7 power-down mid slot");
    run_frame(0, 1, 0, -1, 8'hE7, "R7 held down");
    pdn = 1'b0;
    run_frame(0, 1, 0, -1, 8'h18, "R8 first sync after release");
    run_frame(0, 1, 1, -1, 8'hA5, "R8 second sync opens slot");
    run_frame(0, 2, 1, -1, 8'h00, "R6 code order");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule